// File: doc/BRIEF.md
# Multi-Target Toffoli Circuit Evaluator

This block evaluates a reversible circuit built from multi-target Toffoli gates over an N-bit Boolean state. Each gate names a set of target lines, and each target line carries its own set of control lines. A target is inverted only when every one of its own controls is 1. Software-side configuration stages one control mask per line, then commits a gate by index with its target mask. A commit is checked: a gate with no targets, or one whose targets are also among its own controls, is refused and flagged.

After a start pulse the block latches the input assignment and applies one gate per clock. In forward mode it runs from the first gate to the last. In inverse mode it runs from the last gate to the first. Every gate is its own inverse, so an inverse run undoes a forward run. A one-cycle done pulse marks the end of the run, and the result then stays on the output. The block also reports the circuit's waiting degree. This is the sum, over all loaded gates, of the gate's zero-based position times its number of targets.

Top module: `mtt_eval`

## Requirements
- R1: While and after reset, before any command, state_o, done_o, busy_o, cfg_err_o and wait_o are all 0.
- R2: The configuration opcode sits on cfg_op_i (0 no-op, 1 stage, 2 commit, 3 set length). A commit (cfg_idx_i = gate index) with cfg_data_i = 0 is refused. A commit with gate index >= MAX_GATES is refused. A length write (cfg_idx_i = gate count) above MAX_GATES is refused. On any refusal cfg_err_o is 1 in the cycle after the command, and the stored circuit does not change.
- R3: A stage command writes cfg_data_i as the control mask of line cfg_idx_i. A commit is refused, as in R2, when the OR of the staged masks of its target lines overlaps its target mask. Staged masks of lines that are not targets are ignored. An accepted commit leaves cfg_err_o at 0.
- R4: Within a gate, line i (bit i) is inverted exactly when bit i of the target mask is 1 and all bits of line i's control mask are 1 in the state. A target with an empty control mask is always inverted. Lines that are not targets are passed through unchanged.
- R5: In forward mode (inv_i = 0 at start) gates 0 to n-1 are applied in order. n is the stored length.
- R6: One gate is applied per clock. done_o is high for one cycle, n cycles after the cycle in which start is taken. state_o then holds the result and stays stable while the block is idle.
- R7: In inverse mode (inv_i = 1 at start) gates n-1 down to 0 are applied. Running the forward result through the inverse mode gives back the original input.
- R8: wait_o equals the sum over j = 0..n-1 of j times the number of 1 bits in gate j's target mask.
- R9: Splitting a gate into two consecutive gates with disjoint target subsets gives the same circuit result. Each part keeps the same per-target controls.
- R10: While busy_o is 1, start_i and all configuration commands are ignored, and cfg_err_o stays 0. With n = 0, a start gives done_o in the next cycle with state_o equal to state_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_op_i | input | 2 | Configuration opcode: 0 none, 1 stage, 2 commit, 3 set length |
| cfg_idx_i | input | IW | Line index, gate index or gate count |
| cfg_data_i | input | N_LINES | Control mask (stage) or target mask (commit) |
| cfg_err_o | output | 1 | High one cycle after a refused command |
| start_i | input | 1 | Start a run (taken when idle) |
| inv_i | input | 1 | Run direction, sampled with start |
| state_i | input | N_LINES | Input assignment, sampled with start |
| state_o | output | N_LINES | Current or final state |
| busy_o | output | 1 | Gates being applied |
| done_o | output | 1 | One-cycle pulse after the last gate |
| wait_o | output | WW | Waiting degree of the stored circuit |

## Verification
A wrong stored gate or a wrong control decode shows up in state_o at the done pulse of the next run. A sequencing error shows up as a done pulse that comes earlier or later than n cycles after start, or as an inverse run that does not give back the input. A corrupted target mask, or a refused commit that was still written, also changes wait_o in the cycle right after the command. The checks therefore compare the final state, the done timing and wait_o against values worked out by hand for one fixed circuit and for its split version.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  typedef enum logic [1:0] {
    CFG_NOP    = 2'd0,
    CFG_STAGE  = 2'd1,
    CFG_COMMIT = 2'd2,
    CFG_LEN    = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/mtt_gate_apply.sv
module mtt_gate_apply #(
  parameter int N_LINES = 8
) (
  input  logic [N_LINES-1:0] state_i,
  input  logic [N_LINES-1:0] tgt_i,
  input  logic [N_LINES-1:0] ctl_i [N_LINES],
  output logic [N_LINES-1:0] state_o
);
  // every target sees the pre-gate state
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign state_o[i] = state_i[i] ^ (tgt_i[i] & ((ctl_i[i] & state_i) == ctl_i[i]));
  end
endmodule

// File: rtl/mtt_cfg_store.sv
module mtt_cfg_store
  import mtt_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int MAX_GATES = 16,
  parameter int IW        = 5,
  parameter int GW        = 4,
  parameter int WW        = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  cfg_op_e            op_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [N_LINES-1:0] data_i,
  output logic               err_o,
  output logic [IW-1:0]      len_o,
  input  logic [GW-1:0]      rd_idx_i,
  output logic [N_LINES-1:0] rd_tgt_o,
  output logic [N_LINES-1:0] rd_ctl_o [N_LINES],
  output logic [WW-1:0]      wait_o
);
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] tgt_q [MAX_GATES];
  logic [N_LINES-1:0] ctl_q [MAX_GATES][N_LINES];
  logic [N_LINES-1:0] stg_q [N_LINES];
  logic [IW-1:0]      len_q;
  logic               err_q;
  logic [N_LINES-1:0] ctl_union;
  logic               bad_commit;
  logic [WW-1:0]      wait_acc;

  always_comb begin
    ctl_union = '0;
    for (int i = 0; i < N_LINES; i++)
      if (data_i[i]) ctl_union |= stg_q[i];
  end

  assign bad_commit = (data_i == '0) || ((ctl_union & data_i) != '0) ||
                      (idx_i >= IW'(MAX_GATES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      err_q <= 1'b0;
      for (int g = 0; g < MAX_GATES; g++) begin
        tgt_q[g] <= '0;
        for (int i = 0; i < N_LINES; i++) ctl_q[g][i] <= '0;
      end
      for (int i = 0; i < N_LINES; i++) stg_q[i] <= '0;
    end else begin
      err_q <= 1'b0;
      if (!busy_i) begin
        case (op_i)
          CFG_STAGE: begin
            if (idx_i < IW'(N_LINES)) stg_q[idx_i[LW-1:0]] <= data_i;
            else err_q <= 1'b1;
          end
          CFG_COMMIT: begin
            if (bad_commit) err_q <= 1'b1;
            else begin
              tgt_q[idx_i[GW-1:0]] <= data_i;
              for (int i = 0; i < N_LINES; i++)
                ctl_q[idx_i[GW-1:0]][i] <= data_i[i] ? stg_q[i] : '0;
            end
          end
          CFG_LEN: begin
            if (idx_i > IW'(MAX_GATES)) err_q <= 1'b1;
            else len_q <= idx_i;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    wait_acc = '0;
    for (int g = 0; g < MAX_GATES; g++)
      if (IW'(g) < len_q) wait_acc += WW'(g) * WW'($countones(tgt_q[g]));
  end

  assign err_o    = err_q;
  assign len_o    = len_q;
  assign wait_o   = wait_acc;
  assign rd_tgt_o = tgt_q[rd_idx_i];
  for (genvar i = 0; i < N_LINES; i++) begin : g_rd
    assign rd_ctl_o[i] = ctl_q[rd_idx_i][i];
  end

  AST_EMPTY_TGT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && op_i == CFG_COMMIT && data_i == '0) |=> err_o); // R2
  AST_OVERLAP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && op_i == CFG_COMMIT && (ctl_union & data_i) != '0) |=> err_o); // R3
  AST_BUSY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !err_o); // R10
endmodule

// File: rtl/mtt_seq.sv
module mtt_seq #(
  parameter int N_LINES   = 8,
  parameter int MAX_GATES = 16,
  parameter int IW        = 5,
  parameter int GW        = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               inv_i,
  input  logic [N_LINES-1:0] state_i,
  input  logic [IW-1:0]      len_i,
  input  logic [N_LINES-1:0] nxt_i,
  input  logic [N_LINES-1:0] tgt_i,
  output logic [GW-1:0]      pc_o,
  output logic [N_LINES-1:0] state_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [N_LINES-1:0] state_q;
  logic [GW-1:0]      pc_q;
  logic [IW-1:0]      left_q;
  logic               busy_q, done_q, inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      pc_q    <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        state_q <= state_i;
        inv_q   <= inv_i;
        if (len_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          left_q <= len_i - 1'b1;
          pc_q   <= inv_i ? GW'(len_i - 1'b1) : '0;
        end
      end else if (busy_q) begin
        state_q <= nxt_i;
        if (left_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
          pc_q   <= inv_q ? pc_q - 1'b1 : pc_q + 1'b1;
        end
      end
    end
  end

  assign pc_o    = pc_q;
  assign state_o = state_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> !done_q); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(state_q)); // R6
  AST_NONTGT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ((state_q ^ $past(state_q)) & ~$past(tgt_i)) == '0); // R4
endmodule

// File: rtl/mtt_eval.sv
module mtt_eval
  import mtt_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int MAX_GATES = 16,
  localparam int IW = $clog2(MAX_GATES + 1) > $clog2(N_LINES) ?
                      $clog2(MAX_GATES + 1) : $clog2(N_LINES),
  localparam int WW = $clog2((MAX_GATES * (MAX_GATES - 1) / 2) * N_LINES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cfg_op_i,
  input  logic [IW-1:0]      cfg_idx_i,
  input  logic [N_LINES-1:0] cfg_data_i,
  output logic               cfg_err_o,
  input  logic               start_i,
  input  logic               inv_i,
  input  logic [N_LINES-1:0] state_i,
  output logic [N_LINES-1:0] state_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [WW-1:0]      wait_o
);
  localparam int GW = (MAX_GATES > 1) ? $clog2(MAX_GATES) : 1;

  logic [GW-1:0]      pc;
  logic [IW-1:0]      len;
  logic [N_LINES-1:0] gate_tgt, nxt;
  logic [N_LINES-1:0] gate_ctl [N_LINES];

  mtt_cfg_store #(
    .N_LINES(N_LINES), .MAX_GATES(MAX_GATES), .IW(IW), .GW(GW), .WW(WW)
  ) u_store (
    .clk_i, .rst_ni,
    .busy_i  (busy_o),
    .op_i    (cfg_op_e'(cfg_op_i)),
    .idx_i   (cfg_idx_i),
    .data_i  (cfg_data_i),
    .err_o   (cfg_err_o),
    .len_o   (len),
    .rd_idx_i(pc),
    .rd_tgt_o(gate_tgt),
    .rd_ctl_o(gate_ctl),
    .wait_o  (wait_o)
  );

  mtt_gate_apply #(.N_LINES(N_LINES)) u_apply (
    .state_i(state_o),
    .tgt_i  (gate_tgt),
    .ctl_i  (gate_ctl),
    .state_o(nxt)
  );

  mtt_seq #(
    .N_LINES(N_LINES), .MAX_GATES(MAX_GATES), .IW(IW), .GW(GW)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i, .inv_i, .state_i,
    .len_i  (len),
    .nxt_i  (nxt),
    .tgt_i  (gate_tgt),
    .pc_o   (pc),
    .state_o(state_o),
    .busy_o (busy_o),
    .done_o (done_o)
  );
endmodule

// File: tb/tb_mtt_eval.sv
module tb_mtt_eval;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 5;
  localparam int WW = 10;

  typedef struct packed {
    logic       inv;
    logic [7:0] din;
    logic [7:0] dexp;
  } vec_t;

  // circuit A: g0 t{1:c0,2:-} g1 t{3:c1c2,4:c1} g2 t{0:c3c7}
  localparam vec_t VECS [9] = '{
    '{1'b0, 8'h00, 8'h04}, // R5
    '{1'b0, 8'h01, 8'h1F}, // R4 R5
    '{1'b0, 8'h81, 8'h9E}, // R5
    '{1'b0, 8'hFF, 8'hF8}, // R4
    '{1'b0, 8'h0E, 8'h1A}, // R5
    '{1'b1, 8'h04, 8'h00}, // R7
    '{1'b1, 8'h1F, 8'h01}, // R7
    '{1'b1, 8'h9E, 8'h81}, // R7
    '{1'b1, 8'h01, 8'h07}  // R7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_op = 2'd0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0, st_in = '0;
  logic start = 1'b0, inv = 1'b0;
  logic cfg_err, busy, done;
  logic [7:0] st_out;
  logic [WW-1:0] wait_deg;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mtt_eval dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_op_i(cfg_op), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .cfg_err_o(cfg_err),
    .start_i(start), .inv_i(inv), .state_i(st_in),
    .state_o(st_out), .busy_o(busy), .done_o(done), .wait_o(wait_deg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] op, input int idx, input logic [7:0] d,
                     input logic exp_err, input string tag);
    cfg_op = op; cfg_idx = IW'(idx); cfg_data = d;
    @(negedge clk);
    cfg_op = 2'd0;
    chk(tag, 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic run(input logic iv, input logic [7:0] din, input logic [7:0] dexp,
                     input int exp_cyc, input string tag);
    int cyc;
    start = 1'b1; inv = iv; st_in = din;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " state"}, 32'(st_out), 32'(dexp));
    chk({tag, " cycles"}, 32'(cyc), 32'(exp_cyc));
  endtask

  task automatic load_a();
    cfg(2'd1, 1, 8'h01, 1'b0, "R3 stage");
    cfg(2'd1, 2, 8'h00, 1'b0, "R3 stage");
    cfg(2'd2, 0, 8'h06, 1'b0, "R3 commit ok g0");
    cfg(2'd1, 3, 8'h06, 1'b0, "R3 stage");
    cfg(2'd1, 4, 8'h02, 1'b0, "R3 stage");
    cfg(2'd2, 1, 8'h18, 1'b0, "R3 commit ok g1");
    cfg(2'd1, 0, 8'h88, 1'b0, "R3 stage");
    // stale line1 mask covers bit0 but line1 is no target here
    cfg(2'd2, 2, 8'h01, 1'b0, "R3 non-target staged mask ignored");
    cfg(2'd3, 3, 8'h00, 1'b0, "R2 length ok");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 32'(st_out), 0);
    chk("R1 reset done/busy/err", {29'd0, done, busy, cfg_err}, 0);
    chk("R1 reset wait", 32'(wait_deg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset state", 32'(st_out), 0);

    load_a();
    chk("R8 wait circuit A", 32'(wait_deg), 4);

    for (int k = 0; k < 9; k++)
      run(VECS[k].inv, VECS[k].din, VECS[k].dexp, 3,
          VECS[k].inv ? "R7 inverse vec" : "R5 forward vec");

    held = st_out;
    repeat (3) begin
      @(negedge clk);
      chk("R6 result held", 32'(st_out), 32'(held));
      chk("R6 done single pulse", 32'(done), 0);
    end

    // busy: second start and a commit must be ignored
    start = 1'b1; inv = 1'b0; st_in = 8'h01;
    @(negedge clk);
    start = 1'b1; st_in = 8'hFF; cfg_op = 2'd2; cfg_idx = '0; cfg_data = 8'h80;
    @(negedge clk);
    start = 1'b0; cfg_op = 2'd0;
    chk("R10 no err while busy", 32'(cfg_err), 0);
    while (!done) @(negedge clk);
    chk("R10 busy start ignored", 32'(st_out), 32'h1F);
    chk("R10 busy commit ignored wait", 32'(wait_deg), 4);
    run(1'b0, 8'h81, 8'h9E, 3, "R10 circuit intact");

    cfg(2'd2, 1, 8'h00, 1'b1, "R2 empty target refused");
    cfg(2'd2, 16, 8'h01, 1'b1, "R2 gate index refused");
    cfg(2'd3, 17, 8'h00, 1'b1, "R2 length refused");
    chk("R2 wait unchanged", 32'(wait_deg), 4);
    cfg(2'd1, 5, 8'h20, 1'b0, "R3 stage self");
    cfg(2'd1, 6, 8'h01, 1'b0, "R3 stage");
    cfg(2'd2, 1, 8'h20, 1'b1, "R3 self overlap refused");
    cfg(2'd1, 0, 8'h02, 1'b0, "R3 stage");
    cfg(2'd2, 1, 8'h03, 1'b1, "R3 cross overlap refused");
    run(1'b0, 8'h01, 8'h1F, 3, "R2 R3 circuit unchanged");

    cfg(2'd3, 0, 8'h00, 1'b0, "R10 length zero");
    chk("R8 wait empty", 32'(wait_deg), 0);
    run(1'b0, 8'h5A, 8'h5A, 0, "R10 zero-length run");

    // split g0 of A into {1} and {2}
    cfg(2'd1, 1, 8'h01, 1'b0, "R9 stage");
    cfg(2'd1, 2, 8'h00, 1'b0, "R9 stage");
    cfg(2'd2, 0, 8'h02, 1'b0, "R9 commit part a");
    cfg(2'd2, 1, 8'h04, 1'b0, "R9 commit part b");
    cfg(2'd1, 3, 8'h06, 1'b0, "R9 stage");
    cfg(2'd1, 4, 8'h02, 1'b0, "R9 stage");
    cfg(2'd2, 2, 8'h18, 1'b0, "R9 commit");
    cfg(2'd1, 0, 8'h88, 1'b0, "R9 stage");
    cfg(2'd2, 3, 8'h01, 1'b0, "R9 commit");
    cfg(2'd3, 4, 8'h00, 1'b0, "R9 length");
    chk("R8 wait split circuit", 32'(wait_deg), 8);
    run(1'b0, 8'h01, 8'h1F, 4, "R9 split fwd");
    run(1'b0, 8'h81, 8'h9E, 4, "R9 split fwd");
    run(1'b0, 8'hFF, 8'hF8, 4, "R9 split fwd");
    run(1'b1, 8'hF8, 8'hFF, 4, "R7 R9 split inverse");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule